// File: doc/BRIEF.md
# Memory-Type-Aware Data Cache Controller

This controller sits between a CPU load/store port and memory and owns a small direct-mapped write-back data cache. Every request carries a two-bit memory-type tag, and the tag selects how the access is serviced: write-back (cached), cache-disable (uncached, but it must clean up any copy already held in the cache), or uncacheable (uncached, never touches the cache, and strictly ordered behind any buffered stores).

Only one request is in flight at a time. The CPU raises `cpuReq` while `cpuReady` is high. The controller then keeps `cpuReady` low while it works through the sequence for that memory type. This can include a line write-back, a line refill, an invalidation, a handshake that drains an external write buffer, and a single-word memory access. It ends with a one-cycle `cpuDone` pulse that carries read data. Memory transfers are either a whole line or a single word, and each is held until acknowledged.

Top module: `mt_cache_ctrl`

## Requirements
- R1: After reset, `cpuReady` is 1, `memReq` and `flushReq` are 0, and every cache line is invalid, so the first cached read of any address misses without writing anything back.
- R2: A write-back (type 00) read that misses on a clean or invalid line issues one line read at the line-aligned address. It installs the line and returns the addressed word. Word k of a line is at bits [32k+31:32k] of the line bus and at byte offset 4k.
- R3: A write-back access that hits is completed with no memory or flush traffic. A write hit updates the word and marks the line dirty.
- R4: A write-back miss whose victim line is dirty first writes the whole victim line back to the victim's own address, and only then refills.
- R5: An uncacheable access (type 10 or 11) first completes a flush request/acknowledge handshake. Only after that does it perform exactly one single-word memory access. It never allocates, so a later cached access to that address still misses.
- R6: Uncacheable writes are never merged. Each one produces its own single-word memory write carrying its own data, even for neighbouring words of one line.
- R7: A cache-disable access (type 01) that hits a clean line invalidates that line and does a single-word memory access, with no line write.
- R8: A cache-disable access that hits a dirty line writes that line back, invalidates it, and then does the single-word access. A read therefore returns the freshly written-back data.
- R9: A cache-disable access that misses does only the single-word access and replaces no line. The line already at that index stays resident.
- R10: From acceptance until the `cpuDone` pulse, `cpuReady` stays low. `cpuDone` is never high while `cpuReady` is high.
- R11: `flushReq` is raised only for uncacheable accesses, is held until `flushAck`, and never overlaps `memReq`.
- R12: Type code 11 behaves exactly like code 10 (uncacheable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request strobe, accepted while cpuReady is high |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuType | input | 2 | 00 write-back, 01 cache-disable, 10/11 uncacheable |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Controller idle and able to accept |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Load data, valid with cpuDone |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = memory write |
| memLine | output | 1 | 1 = whole-line transfer, 0 = single word |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 128 | Line write data, or the word in bits 31:0 |
| memRdata | input | 128 | Line read data, or the word in bits 31:0 |
| memAck | input | 1 | One-cycle acknowledge of memReq |
| flushReq | output | 1 | Request to drain the external write buffer |
| flushAck | input | 1 | Write buffer drained |

## Verification
How long an access takes depends on its type and on how fast memory and the write buffer answer. The bench therefore waits on handshakes instead of fixed cycle counts. Read data is due in the same cycle as `cpuDone`: a hit is captured one cycle after acceptance, and a word read is captured on its `memAck` edge. Both are sampled on the falling edge while `cpuDone` is high. The memory and flush responders answer on falling edges and log each transaction in order. That log is compared, entry by entry, with the sequence a bench reference cache predicts for the access. `cpuReady` is sampled low on every falling edge between acceptance and done.

// File: rtl/mt_cache_pkg.sv
package mt_cache_pkg;
  typedef enum logic [1:0] {
    MT_WB  = 2'b00,
    MT_CD  = 2'b01,
    MT_UC  = 2'b10,
    MT_UC2 = 2'b11
  } memType_t;

  typedef enum logic [1:0] {
    MS_WORD   = 2'b00,
    MS_VICTIM = 2'b01,
    MS_FILL   = 2'b10
  } memSel_t;

  typedef struct packed {
    logic    capReq;
    logic    fillLine;
    logic    hitWrite;
    logic    cleanLine;
    logic    dropLine;
    logic    capMem;
    logic    capHit;
    memSel_t memSel;
  } ctlStrobe_t;
endpackage

// File: rtl/mt_cache_datapath.sv
module mt_cache_datapath
  import mt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   ctl,
  input  logic                         cpuWe,
  input  logic [1:0]                   cpuType,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata,
  output memType_t                     reqType,
  output logic                         reqWe,
  output logic                         hit,
  output logic                         victimDirty,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0]            rdata
);
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqWdata;
  logic [LINES-1:0]  validArr, dirtyArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINE_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WSEL_W-1:0] wordSel;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign wordSel = reqAddr[BYTE_W +: WSEL_W];

  assign hit         = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[reqIdx] && dirtyArr[reqIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      reqType  <= MT_WB;
      validArr <= '0;
      dirtyArr <= '0;
      rdata    <= '0;
    end else begin
      if (ctl.capReq) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqWe    <= cpuWe;
        reqType  <= memType_t'(cpuType);
      end
      if (ctl.fillLine) begin
        validArr[reqIdx] <= 1'b1;
        dirtyArr[reqIdx] <= 1'b0;
      end else if (ctl.hitWrite) begin
        dirtyArr[reqIdx] <= 1'b1;
      end else if (ctl.cleanLine) begin
        dirtyArr[reqIdx] <= 1'b0;
      end else if (ctl.dropLine) begin
        validArr[reqIdx] <= 1'b0;
        dirtyArr[reqIdx] <= 1'b0;
      end
      if (ctl.capHit) rdata <= dataArr[reqIdx][wordSel*WORD_W +: WORD_W];
      else if (ctl.capMem) rdata <= memRdata[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillLine) begin
      dataArr[reqIdx] <= memRdata;
      tagArr[reqIdx]  <= reqTag;
    end else if (ctl.hitWrite) begin
      dataArr[reqIdx][wordSel*WORD_W +: WORD_W] <= reqWdata;
    end
  end

  always_comb begin
    memWdata = {{(LINE_W-WORD_W){1'b0}}, reqWdata};
    case (ctl.memSel)
      MS_VICTIM: begin
        memAddr  = {tagArr[reqIdx], reqIdx, {OFF_W{1'b0}}};
        memWdata = dataArr[reqIdx];
      end
      MS_FILL: memAddr = {reqTag, reqIdx, {OFF_W{1'b0}}};
      default: memAddr = reqAddr;
    endcase
  end

  // R5
  fill_wb_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillLine |-> (reqType == MT_WB));
  // R7
  drop_clears_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dropLine |=> !hit);
  // R4
  fill_after_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillLine |-> !victimDirty);
endmodule

// File: rtl/mt_cache_control.sv
module mt_cache_control
  import mt_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       memAck,
  input  logic       flushAck,
  input  memType_t   reqType,
  input  logic       reqWe,
  input  logic       hit,
  input  logic       victimDirty,
  output ctlStrobe_t ctl,
  output logic       cpuReady,
  output logic       cpuDone,
  output logic       memReq,
  output logic       memWe,
  output logic       memLine,
  output logic       flushReq
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_FLUSH, S_EVICT, S_FILL, S_WORD, S_DONE
  } state_t;

  state_t state, nextState;
  logic   flushDone;
  logic   isUc;

  assign isUc = (reqType == MT_UC) || (reqType == MT_UC2);

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.memSel = MS_WORD;
    cpuReady  = 1'b0;
    cpuDone   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memLine   = 1'b0;
    flushReq  = 1'b0;
    case (state)
      S_IDLE: begin
        cpuReady = 1'b1;
        if (cpuReq) begin
          ctl.capReq = 1'b1;
          nextState  = S_LOOK;
        end
      end
      S_LOOK: begin
        case (reqType)
          MT_WB: begin
            if (hit) begin
              ctl.hitWrite = reqWe;
              ctl.capHit   = !reqWe;
              nextState    = S_DONE;
            end else if (victimDirty) nextState = S_EVICT;
            else nextState = S_FILL;
          end
          MT_CD: begin
            if (hit && victimDirty) nextState = S_EVICT;
            else begin
              ctl.dropLine = hit;
              nextState    = S_WORD;
            end
          end
          default: nextState = S_FLUSH;
        endcase
      end
      S_FLUSH: begin
        flushReq = 1'b1;
        if (flushAck) nextState = S_WORD;
      end
      S_EVICT: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        memLine    = 1'b1;
        ctl.memSel = MS_VICTIM;
        if (memAck) begin
          if (reqType == MT_WB) begin
            ctl.cleanLine = 1'b1;
            nextState     = S_FILL;
          end else begin
            ctl.dropLine = 1'b1;
            nextState    = S_WORD;
          end
        end
      end
      S_FILL: begin
        memReq     = 1'b1;
        memLine    = 1'b1;
        ctl.memSel = MS_FILL;
        if (memAck) begin
          ctl.fillLine = 1'b1;
          nextState    = S_LOOK;
        end
      end
      S_WORD: begin
        memReq = 1'b1;
        memWe  = reqWe;
        if (memAck) begin
          ctl.capMem = 1'b1;
          nextState  = S_DONE;
        end
      end
      default: begin
        cpuDone   = 1'b1;
        nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      flushDone <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.capReq) flushDone <= 1'b0;
      else if (flushReq && flushAck) flushDone <= 1'b1;
    end
  end

  // R5
  uc_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memLine && isUc) |-> flushDone);
  // R11
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushAck) |=> flushReq);
  // R11
  flush_uc_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (isUc && !memReq));
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !cpuReady);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
endmodule

// File: rtl/mt_cache_ctrl.sv
module mt_cache_ctrl
  import mt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic [1:0]                   cpuType,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic                         cpuReady,
  output logic                         cpuDone,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         memReq,
  output logic                         memWe,
  output logic                         memLine,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata,
  input  logic                         memAck,
  output logic                         flushReq,
  input  logic                         flushAck
);
  ctlStrobe_t ctl;
  memType_t   reqType;
  logic       reqWe, hit, victimDirty;

  mt_cache_control u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .memAck(memAck),
    .flushAck(flushAck), .reqType(reqType), .reqWe(reqWe), .hit(hit),
    .victimDirty(victimDirty), .ctl(ctl), .cpuReady(cpuReady),
    .cpuDone(cpuDone), .memReq(memReq), .memWe(memWe),
    .memLine(memLine), .flushReq(flushReq)
  );

  mt_cache_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuWe(cpuWe), .cpuType(cpuType),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memRdata(memRdata),
    .reqType(reqType), .reqWe(reqWe), .hit(hit), .victimDirty(victimDirty),
    .memAddr(memAddr), .memWdata(memWdata), .rdata(cpuRdata)
  );
endmodule

// File: tb/tb_mt_cache_ctrl.sv
module tb_mt_cache_ctrl;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0;
  logic [1:0]   cpuType = 2'b00;
  logic [31:0]  cpuAddr = '0, cpuWdata = '0;
  logic         cpuReady, cpuDone;
  logic [31:0]  cpuRdata;
  logic         memReq, memWe, memLine;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata = '0;
  logic         memAck = 1'b0;
  logic         flushReq;
  logic         flushAck = 1'b0;

  int total = 0;
  int bad = 0;
  int flushWait = 0;
  bit overlapBad = 0;

  logic [31:0] memStore [logic [31:0]];
  int          logN;
  int          logKind [8];
  logic [31:0] logAddr [8];
  logic [127:0] logData [8];
  int          expN;
  int          expKind [8];
  logic [31:0] expAddr [8];
  logic [127:0] expData [8];

  bit          refValid [16];
  bit          refDirty [16];
  logic [23:0] refTag [16];
  logic [31:0] refData [16][4];

  always #10 clk = ~clk;

  mt_cache_ctrl dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuType(cpuType),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe),
    .memLine(memLine), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .flushReq(flushReq),
    .flushAck(flushAck)
  );

  function automatic logic [31:0] memWordAt(input logic [31:0] a);
    if (memStore.exists(a)) return memStore[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mk(input logic [23:0] tag, input int idx, input int w);
    return {tag, idx[3:0], w[1:0], 2'b00};
  endfunction

  // kinds: 0 flush, 1 line write, 2 line read, 3 word write, 4 word read
  task automatic addLog(input int k, input logic [31:0] a, input logic [127:0] d);
    if (logN < 8) begin
      logKind[logN] = k; logAddr[logN] = a; logData[logN] = d;
    end
    logN++;
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0;
      flushAck = 1'b0;
    end else begin
      if (memReq && !memAck) begin
        if (flushReq) overlapBad = 1;
        if (memLine && memWe) begin
          for (int i = 0; i < 4; i++) memStore[memAddr + 32'(4*i)] = memWdata[32*i +: 32];
          addLog(1, memAddr, memWdata);
        end else if (memLine) begin
          for (int i = 0; i < 4; i++) memRdata[32*i +: 32] = memWordAt(memAddr + 32'(4*i));
          addLog(2, memAddr, '0);
        end else if (memWe) begin
          memStore[memAddr] = memWdata[31:0];
          addLog(3, memAddr, {96'b0, memWdata[31:0]});
        end else begin
          memRdata = {96'b0, memWordAt(memAddr)};
          addLog(4, memAddr, '0);
        end
        memAck = 1'b1;
      end else memAck = 1'b0;
      if (flushReq && !flushAck) begin
        if (flushWait == 2) begin
          flushAck = 1'b1;
          flushWait = 0;
          addLog(0, '0, '0);
        end else flushWait++;
      end else flushAck = 1'b0;
    end
  end

  task automatic check(input string req, input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [31:0] a, input logic [127:0] d);
    expKind[expN] = k; expAddr[expN] = a; expData[expN] = d;
    expN++;
  endtask

  function automatic logic [127:0] refLine(input int idx);
    return {refData[idx][3], refData[idx][2], refData[idx][1], refData[idx][0]};
  endfunction

  task automatic access(input logic [1:0] ty, input bit we, input logic [31:0] addr,
                        input logic [31:0] wd, input string req);
    int idx = int'(addr[7:4]);
    int w = int'(addr[3:2]);
    logic [23:0] tag = addr[31:8];
    bit hitM = refValid[idx] && (refTag[idx] == tag);
    logic [31:0] expR = '0;
    bit busyBad = 0;
    int waitCnt = 0;
    bit seqOk;
    expN = 0;
    if (ty[1]) begin
      push(0, '0, '0);
      if (we) push(3, addr, {96'b0, wd});
      else begin push(4, addr, '0); expR = memWordAt(addr); end
    end else if (ty == 2'b01) begin
      if (hitM && refDirty[idx]) begin
        push(1, {tag, idx[3:0], 4'b0}, refLine(idx));
        expR = refData[idx][w];
      end else expR = memWordAt(addr);
      if (hitM) begin refValid[idx] = 0; refDirty[idx] = 0; end
      if (we) push(3, addr, {96'b0, wd}); else push(4, addr, '0);
    end else begin
      if (!hitM) begin
        if (refValid[idx] && refDirty[idx])
          push(1, {refTag[idx], idx[3:0], 4'b0}, refLine(idx));
        push(2, {tag, idx[3:0], 4'b0}, '0);
        for (int i = 0; i < 4; i++)
          refData[idx][i] = (refValid[idx] && refDirty[idx] && 0) ? '0 :
                            memWordAt({tag, idx[3:0], 4'b0} + 32'(4*i));
        refValid[idx] = 1; refDirty[idx] = 0; refTag[idx] = tag;
      end
      if (we) begin refData[idx][w] = wd; refDirty[idx] = 1; end
      else expR = refData[idx][w];
    end
    @(negedge clk);
    while (!cpuReady && waitCnt < 100) begin @(negedge clk); waitCnt++; end
    logN = 0;
    cpuReq = 1'b1; cpuWe = we; cpuType = ty; cpuAddr = addr; cpuWdata = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    waitCnt = 0;
    while (!cpuDone && waitCnt < 100) begin
      if (cpuReady) busyBad = 1;
      @(negedge clk);
      waitCnt++;
    end
    check(req, cpuDone && !busyBad, "R10 busy until done", {127'b0, busyBad}, '0);
    if (!we) check(req, cpuRdata == expR, "read data", cpuRdata, expR);
    seqOk = (logN == expN);
    if (!seqOk)
      check(req, 0, "transaction count", logN, expN);
    else begin
      for (int i = 0; i < expN; i++)
        if (logKind[i] != expKind[i] || logAddr[i] != expAddr[i] ||
            ((expKind[i] == 1 || expKind[i] == 3) && logData[i] != expData[i])) begin
          seqOk = 0;
          check(req, 0, "transaction", {logKind[i], logAddr[i], logData[i][63:0]},
                {expKind[i], expAddr[i], expData[i][63:0]});
        end
      if (seqOk) check(req, 1, "sequence", '0, '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin refValid[i] = 0; refDirty[i] = 0; refTag[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", cpuReady == 1'b1, "cpuReady", cpuReady, 1);
    check("R1", memReq == 1'b0 && flushReq == 1'b0, "memReq/flushReq", {memReq, flushReq}, 0);
    // R1 R2: first reads miss and refill without write-back
    for (int i = 0; i < 16; i++) access(2'b00, 0, mk(24'h000010, i, i % 4), '0, "R2");
    // R3: read hits, no traffic
    for (int i = 0; i < 16; i++) access(2'b00, 0, mk(24'h000010, i, (i + 1) % 4), '0, "R3");
    // R3: write hits make lines dirty
    for (int i = 0; i < 16; i++) access(2'b00, 1, mk(24'h000010, i, 2), 32'hC0DE_0000 + i, "R3");
    for (int i = 0; i < 16; i++) access(2'b00, 0, mk(24'h000010, i, 2), '0, "R3");
    // R4: dirty victims written back before refill
    for (int i = 0; i < 8; i++) access(2'b00, 0, mk(24'h000020, i, 1), '0, "R4");
    // R5: uncacheable read flushes first and does not allocate
    access(2'b10, 0, mk(24'h000077, 3, 1), '0, "R5");
    access(2'b00, 0, mk(24'h000077, 3, 1), '0, "R5");
    // R6: neighbouring uncacheable writes stay separate
    access(2'b10, 1, mk(24'h000078, 5, 0), 32'h1111_AAAA, "R6");
    access(2'b10, 1, mk(24'h000078, 5, 1), 32'h2222_BBBB, "R6");
    access(2'b10, 0, mk(24'h000078, 5, 1), '0, "R6");
    // R12: code 11 acts as uncacheable
    access(2'b11, 0, mk(24'h000078, 5, 0), '0, "R12");
    access(2'b11, 1, mk(24'h000079, 6, 3), 32'h3333_CCCC, "R12");
    // R8: cache-disable hit on dirty line
    access(2'b01, 0, mk(24'h000010, 9, 2), '0, "R8");
    access(2'b00, 0, mk(24'h000010, 9, 0), '0, "R8");
    access(2'b01, 1, mk(24'h000010, 10, 1), 32'h4444_DDDD, "R8");
    access(2'b00, 0, mk(24'h000010, 10, 1), '0, "R8");
    // R7: cache-disable hit on clean line
    access(2'b01, 1, mk(24'h000020, 0, 3), 32'h5555_EEEE, "R7");
    access(2'b00, 0, mk(24'h000020, 0, 3), '0, "R7");
    access(2'b01, 0, mk(24'h000020, 2, 1), '0, "R7");
    // R9: cache-disable miss replaces nothing
    access(2'b01, 0, mk(24'h000099, 1, 2), '0, "R9");
    access(2'b01, 1, mk(24'h000099, 4, 0), 32'h6666_FFFF, "R9");
    access(2'b00, 0, mk(24'h000020, 1, 0), '0, "R9");
    access(2'b00, 0, mk(24'h000020, 4, 0), '0, "R9");
    // R11: flush and memory requests never overlapped
    check("R11", !overlapBad, "flush/mem overlap", {127'b0, overlapBad}, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule